// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt requests for a small 8-bit CPU core. Fifteen sources feed it: one software break request, six external pins and eight one-cycle strobes from internal peripherals. Each source has a request latch. Each maskable source also has an enable bit, and one global disable flag masks all maskable sources at once. The break request cannot be masked.

A fixed priority encoder picks the winner among the eligible requests. It presents the winner's 4-bit vector number and a take-interrupt strobe to the CPU. When the CPU acknowledges, the block sets the global disable flag and clears the winner's request latch. The CPU handles the stack push and the vector fetch.

The external pins pass through a synchronizer. Each pin then goes through a programmable polarity stage, so a change of polarity can itself latch a request, just as a real edge would. Software may clear request latches but can never set them.

Top module: `irq_ctrl`

## Requirements
- R1: Source numbering for the 4-bit `vec_o`: 0 is the break request, 1..6 are external pins 0..5, 7..14 are internal strobes 0..7. Bit k of `req_o` is source k. Bit k of `en_o`/`en_wdata_i` enables source k+1.
- R2: A maskable source k is eligible only when `req_o[k]`=1, `en_o[k-1]`=1 and `dis_o`=0. Otherwise it never raises `take_o`.
- R3: A write with `clr_we_i`=1 clears `req_o[k+1]` for every bit k of `clr_wdata_i` that is 0. Bits written as 1 leave their requests unchanged and never set them.
- R4: A write with `en_we_i`=1 loads `en_wdata_i` into the enable bits, and `en_o` reads them back on the next cycle.
- R5: A pending break request (`req_o[0]`=1) raises `take_o` with `vec_o`=0 whatever the enable bits and `dis_o` hold.
- R6: When several sources are eligible, `vec_o` gives the lowest-numbered one.
- R7: When `ack_i`=1 while `take_o`=1, on that clock edge `dis_o` becomes 1 and the request of source `vec_o` is cleared.
- R8: Polarity bit 1 (the reset value) selects rising edges and 0 selects falling edges. A selected edge on an external pin shows in `req_o` three clock edges after the edge that first samples the pin. An edge of the other direction sets nothing.
- R9: Writing a polarity bit that makes the polarity-adjusted level of a steady pin go from 0 to 1 sets that pin's request one clock edge after the write takes effect. A change that takes the level from 1 to 0 sets nothing.
- R10: `take_o` and `vec_o` are combinational from the pending state. After an accepted acknowledge with no break pending, `take_o` is 0 in the next cycle.
- R11: If a hardware event sets a request in the same cycle as a software or acknowledge clear of that request, the request ends up set.
- R12: After reset, all requests and enables are 0, `dis_o`=1, all polarity bits are 1 and `take_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_i | input | 6 | External interrupt pins (asynchronous) |
| int_req_i | input | 8 | Internal peripheral request strobes |
| brk_req_i | input | 1 | Software break request strobe |
| en_we_i | input | 1 | Enable register write |
| en_wdata_i | input | 14 | Enable write data |
| en_o | output | 14 | Enable bits |
| clr_we_i | input | 1 | Request clear write |
| clr_wdata_i | input | 14 | Clear mask; 0 clears, 1 keeps |
| pol_we_i | input | 1 | Polarity register write |
| pol_wdata_i | input | 6 | Polarity data, 1 rising, 0 falling |
| pol_o | output | 6 | Polarity bits |
| dis_we_i | input | 1 | Global disable flag write |
| dis_wdata_i | input | 1 | Global disable write value |
| dis_o | output | 1 | Global disable flag |
| req_o | output | 15 | Pending request latches |
| take_o | output | 1 | Take-interrupt strobe to CPU |
| vec_o | output | 4 | Winning vector number |
| ack_i | input | 1 | CPU acceptance of the offered interrupt |

## Verification
A request latch can receive a hardware set and a clear in the same cycle. The clear can come from a software write or from the acknowledge of the same source. The bench provokes this by strobing an internal source in the same cycle as a clear write that names it with a 0. The latch must still read as set afterwards. The bench also checks that acknowledge and disable updates land on the same edge by sampling `dis_o`, `req_o` and `take_o` one cycle after the acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_N_EXT = 6;
  localparam int unsigned IRQ_N_INT = 8;
  localparam int unsigned IRQ_N_SRC = 1 + IRQ_N_EXT + IRQ_N_INT;
  localparam int unsigned IRQ_VEC_W = $clog2(IRQ_N_SRC);
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic meta_q, sync_q, lvl, lvl_q;
    // polarity applied before edge compare: a polarity flip looks like an edge
    assign lvl = pol_i[g] ? sync_q : ~sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        lvl_q  <= 1'b0;
      end else begin
        meta_q <= pin_i[g];
        sync_q <= meta_q;
        lvl_q  <= lvl;
      end
    end
    assign edge_o[g] = lvl & ~lvl_q;
  end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int unsigned N = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);
  for (genvar g = 0; g < N; g++) begin : g_req
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         req_o[g] <= 1'b0;
      else if (set_i[g])  req_o[g] <= 1'b1;   // set wins over clear
      else if (clr_i[g])  req_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 15,
  localparam int unsigned VW = $clog2(N)
) (
  input  logic [N-1:0]  elig_i,
  output logic          any_o,
  output logic [VW-1:0] vec_o,
  output logic [N-1:0]  win_o
);
  function automatic logic [VW-1:0] lowest_idx(input logic [N-1:0] v);
    logic [VW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = VW'(i);
    end
    return r;
  endfunction

  assign any_o = |elig_i;
  assign vec_o = lowest_idx(elig_i);
  assign win_o = any_o ? (N'(1) << vec_o) : '0;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_EXT = IRQ_N_EXT,
  parameter int unsigned N_INT = IRQ_N_INT,
  localparam int unsigned N_SRC = 1 + N_EXT + N_INT,
  localparam int unsigned N_MSK = N_SRC - 1,
  localparam int unsigned VW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_pin_i,
  input  logic [N_INT-1:0] int_req_i,
  input  logic             brk_req_i,
  input  logic             en_we_i,
  input  logic [N_MSK-1:0] en_wdata_i,
  output logic [N_MSK-1:0] en_o,
  input  logic             clr_we_i,
  input  logic [N_MSK-1:0] clr_wdata_i,
  input  logic             pol_we_i,
  input  logic [N_EXT-1:0] pol_wdata_i,
  output logic [N_EXT-1:0] pol_o,
  input  logic             dis_we_i,
  input  logic             dis_wdata_i,
  output logic             dis_o,
  output logic [N_SRC-1:0] req_o,
  output logic             take_o,
  output logic [VW-1:0]    vec_o,
  input  logic             ack_i
);
  logic [N_EXT-1:0] ext_edge;
  logic [N_SRC-1:0] set_evt, clr_evt, elig, win;
  logic             accept;

  function automatic logic [N_SRC-1:0] eligible(input logic [N_SRC-1:0] r,
                                                input logic [N_MSK-1:0] e,
                                                input logic d);
    return r & {e & {N_MSK{~d}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o  <= '0;
      pol_o <= '1;
      dis_o <= 1'b1;
    end else begin
      if (en_we_i)  en_o  <= en_wdata_i;
      if (pol_we_i) pol_o <= pol_wdata_i;
      if (accept)        dis_o <= 1'b1;
      else if (dis_we_i) dis_o <= dis_wdata_i;
    end
  end

  irq_edge_det #(.N(N_EXT)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i), .pol_i(pol_o), .edge_o(ext_edge)
  );

  assign set_evt = {int_req_i, ext_edge, brk_req_i};
  assign accept  = take_o & ack_i;
  assign clr_evt = ({~clr_wdata_i, 1'b0} & {N_SRC{clr_we_i}}) | (win & {N_SRC{accept}});

  irq_req_bank #(.N(N_SRC)) u_req (
    .clk(clk), .rst_n(rst_n), .set_i(set_evt), .clr_i(clr_evt), .req_o(req_o)
  );

  assign elig = eligible(req_o, en_o, dis_o);

  irq_prio_enc #(.N(N_SRC)) u_prio (
    .elig_i(elig), .any_o(take_o), .vec_o(vec_o), .win_o(win)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned N_SRC = 15,
  localparam int unsigned VW = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_i,
  input logic             take_o,
  input logic [VW-1:0]    vec_o,
  input logic [N_SRC-1:0] req_o,
  input logic [N_SRC-2:0] en_o,
  input logic             dis_o,
  input logic [N_SRC-1:0] set_evt
);
  p_masked_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o != '0) |-> (!dis_o && en_o[vec_o - VW'(1)] && req_o[vec_o]));

  p_no_sw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((req_o & ~$past(req_o | set_evt)) == '0));

  p_brk_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o[0] |-> (take_o && vec_o == '0));

  p_ack_disables_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && ack_i) |=> dis_o);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && ack_i && !set_evt[vec_o]) |=> !req_o[$past(vec_o)]);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((req_o & $past(set_evt)) == $past(set_evt)));

  p_take_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> req_o[vec_o]);
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .take_o(take_o), .vec_o(vec_o),
  .req_o(req_o), .en_o(en_o), .dis_o(dis_o), .set_evt(set_evt)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ext_pin_i = '0;
  logic [7:0]  int_req_i = '0;
  logic        brk_req_i = 1'b0;
  logic        en_we_i = 1'b0;
  logic [13:0] en_wdata_i = '0;
  logic [13:0] en_o;
  logic        clr_we_i = 1'b0;
  logic [13:0] clr_wdata_i = '1;
  logic        pol_we_i = 1'b0;
  logic [5:0]  pol_wdata_i = '1;
  logic [5:0]  pol_o;
  logic        dis_we_i = 1'b0;
  logic        dis_wdata_i = 1'b0;
  logic        dis_o;
  logic [14:0] req_o;
  logic        take_o;
  logic [3:0]  vec_o;
  logic        ack_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin_i), .int_req_i(int_req_i),
    .brk_req_i(brk_req_i), .en_we_i(en_we_i), .en_wdata_i(en_wdata_i), .en_o(en_o),
    .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i), .pol_we_i(pol_we_i),
    .pol_wdata_i(pol_wdata_i), .pol_o(pol_o), .dis_we_i(dis_we_i),
    .dis_wdata_i(dis_wdata_i), .dis_o(dis_o), .req_o(req_o), .take_o(take_o),
    .vec_o(vec_o), .ack_i(ack_i)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_en(input logic [13:0] v);
    en_we_i = 1'b1; en_wdata_i = v; tick(); en_we_i = 1'b0;
  endtask
  task automatic wr_dis(input logic v);
    dis_we_i = 1'b1; dis_wdata_i = v; tick(); dis_we_i = 1'b0;
  endtask
  task automatic wr_clr(input logic [13:0] v);
    clr_we_i = 1'b1; clr_wdata_i = v; tick(); clr_we_i = 1'b0; clr_wdata_i = '1;
  endtask
  task automatic wr_pol(input logic [5:0] v);
    pol_we_i = 1'b1; pol_wdata_i = v; tick(); pol_we_i = 1'b0;
  endtask
  task automatic strobe_int(input logic [7:0] v);
    int_req_i = v; tick(); int_req_i = '0;
  endtask
  task automatic do_ack();
    ack_i = 1'b1; tick(); ack_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 req", 32'(req_o), 0);
    check("R12 en", 32'(en_o), 0);
    check("R12 dis", 32'(dis_o), 1);
    check("R12 pol", 32'(pol_o), 32'h3f);
    check("R12 take", 32'(take_o), 0);
  endtask

  task automatic t_mask();
    strobe_int(8'h04);                         // source 9
    check("R1 req bit9", 32'(req_o), 32'h0200);
    check("R2 no take en0", 32'(take_o), 0);
    wr_en(14'h0100);
    check("R2 no take dis1", 32'(take_o), 0);
    wr_dis(1'b0);
    check("R2 take", 32'(take_o), 1);
    check("R1 vec9", 32'(vec_o), 9);
    wr_dis(1'b1);
    check("R2 masked by dis", 32'(take_o), 0);
  endtask

  task automatic t_clear();
    wr_clr(14'h3fff);
    check("R3 ones keep", 32'(req_o), 32'h0200);
    wr_clr(14'h3eff);
    check("R3 zero clears", 32'(req_o), 0);
  endtask

  task automatic t_enable();
    wr_en(14'h2a5a);
    check("R4 readback", 32'(en_o), 32'h2a5a);
    wr_en(14'h0000);
    check("R4 readback zero", 32'(en_o), 0);
  endtask

  task automatic t_break();
    brk_req_i = 1'b1; tick(); brk_req_i = 1'b0;
    check("R5 take", 32'(take_o), 1);
    check("R5 vec0", 32'(vec_o), 0);
    do_ack();
    check("R7 brk cleared", 32'(req_o), 0);
    check("R7 dis", 32'(dis_o), 1);
    check("R10 take drop", 32'(take_o), 0);
  endtask

  task automatic t_prio();
    wr_en(14'h3fff);
    strobe_int(8'h21);                         // sources 7 and 12
    wr_dis(1'b0);
    check("R6 vec7", 32'(vec_o), 7);
    check("R10 take", 32'(take_o), 1);
    do_ack();
    check("R7 dis set", 32'(dis_o), 1);
    check("R7 req7 cleared", 32'(req_o), 32'h1000);
    check("R10 take off", 32'(take_o), 0);
    wr_dis(1'b0);
    check("R6 vec12", 32'(vec_o), 12);
    do_ack();
    check("R7 all clear", 32'(req_o), 0);
  endtask

  task automatic t_edges();
    ext_pin_i[2] = 1'b1;                       // rising on pin 2 -> source 3
    tick(2);
    check("R8 not yet", 32'(req_o[3]), 0);
    tick();
    check("R8 rising", 32'(req_o[3]), 1);
    wr_clr(14'h3ffb);
    ext_pin_i[2] = 1'b0; tick(4);
    check("R8 falling ignored", 32'(req_o), 0);
    ext_pin_i[2] = 1'b1; tick(4);
    wr_clr(14'h3ffb);
    wr_pol(6'h33);                             // pin2 and pin3 to falling
    tick();
    check("R9 polarity sets pin3", 32'(req_o), 32'h0010);
    wr_clr(14'h3ff7);
    check("R9 high pin no set", 32'(req_o), 0);
    ext_pin_i[2] = 1'b0; tick(4);
    check("R8 falling sel", 32'(req_o), 32'h0008);
    wr_clr(14'h3ffb);
  endtask

  task automatic t_collide();
    int_req_i = 8'h02;                         // source 8
    clr_we_i = 1'b1; clr_wdata_i = 14'h3f7f;   // clears source 8
    tick();
    int_req_i = '0; clr_we_i = 1'b0; clr_wdata_i = '1;
    check("R11 set wins", 32'(req_o), 32'h0100);
    wr_clr(14'h0000);
  endtask

  initial begin
    fork
      begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_mask();
        t_clear();
        t_enable();
        t_break();
        t_prio();
        t_edges();
        t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule